// File: doc/BRIEF.md
# Source-Selectable Two-Stage Clock Divider

This block derives one slow clock from one of four source clocks. All of its logic runs in a single fast reference clock domain. Each source arrives as a square wave that the reference clock oversamples. The block counts rising edges of the chosen source through two cascaded stages:

- a power-of-two prescaler, dividing by 1, 2, 4 or 8;
- an integer stage, dividing by N+1, where N runs from 0 to 31.

The block drives a divided clock level, a one-cycle tick at the start of every output period, and the index of the source that currently feeds the output.

Software configures the block through one 32-bit control word, using a plain write strobe and a read-back bus. A written value waits in the control word until the current output period ends. Only then is it copied into the active configuration, so a reconfiguration never cuts a period short. A change of source first parks the output low with counting halted. The first rising edge of the new source then starts a fresh period.

Top module: `ckdiv_top`

## Requirements
- R1: After reset, `cfg_rdata` reads 0, `out_clk` and `out_tick` are low and `act_src` is 0. The reset configuration is source 0 with an overall ratio of 1.
- R2: The control word holds three fields:
  - bits 17:16: source index;
  - bits 5:4: prescale shift S;
  - bits 12:8: divider value N.

  These fields read back as written. Every other bit reads 0 and ignores writes, so writing all ones reads back 0x00031F30.
- R3: With `cfg_we` low, the control word keeps its value whatever `cfg_wdata` carries. A read-modify-write that changes one field leaves the other two fields as they were.
- R4: The output period is (N+1)·2^S rising edges of the active source. Stage one wraps every 2^S edges, and stage two counts those wraps up to N. `out_tick` pulses for one reference cycle at the start of each period.
- R5: For a ratio R of 2 or more, `out_clk` is high for the first floor(R/2) source edges of each period and low for the rest. Even ratios therefore give a 50% duty cycle, and odd ratios give a high phase shorter than the low phase.
- R6: For a ratio of 1, `out_clk` follows the level of the active source, two reference cycles later.
- R7: A newly written configuration is applied only at the rising source edge that ends the current output period. Until that edge, the old ratio and duty pattern continue.
- R8: When the applied configuration names a different source, the following happens in order:
  - `act_src` shows the new index from that period boundary onward;
  - `out_clk` is held low and no edges are counted;
  - the first rising edge of the new source starts period position 0 and raises `out_tick`.
- R9: Edges on sources other than the active one change neither `out_clk`, `out_tick` nor the counting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that oversamples all sources |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back, undefined bits zero |
| src_clk | input | 4 | Source clock levels, one bit per source |
| out_clk | output | 1 | Divided clock level |
| out_tick | output | 1 | One-cycle pulse at each output period start |
| act_src | output | 2 | Index of the source feeding the output |

## Verification
The bench sweeps every source, every shift value and a spread of divider values, including 0, 1 and 31. After each source toggle it compares the output level against an arithmetic edge-count model. It also toggles unselected sources in the middle of periods.

Each fault in view has a distinct symptom:
- A design that applied a new configuration mid-period would produce a short period and shift the duty pattern.
- A design that skipped the park phase would emit a high runt, or count an edge of the old source after the switch.
- Ratio-1 mode is hit with both source levels. Getting it wrong shows up as a stuck output.
- Odd ratios expose a wrong rounding of the high phase.

Each configuration ends with a comparison of the tick count against the model. Register writes with junk in the undefined bits catch leaking or wrongly placed fields.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int NSRC    = 4;
  localparam int SEL_W   = $clog2(NSRC);
  localparam int SH_W    = 2;
  localparam int DV_W    = 5;
  localparam int MUX_LSB = 16;
  localparam int SH_LSB  = 4;
  localparam int DV_LSB  = 8;
  localparam int PRE_W   = (1 << SH_W) - 1;
  localparam int POS_W   = DV_W + PRE_W;
  localparam int RAT_W   = POS_W + 1;

  typedef struct packed {
    logic [SEL_W-1:0] mux;
    logic [SH_W-1:0]  sh;
    logic [DV_W-1:0]  dv;
  } cfg_t;

  function automatic logic [31:0] cfg_to_word(cfg_t c);
    logic [31:0] w;
    w = '0;
    w[MUX_LSB +: SEL_W] = c.mux;
    w[SH_LSB  +: SH_W]  = c.sh;
    w[DV_LSB  +: DV_W]  = c.dv;
    return w;
  endfunction
endpackage

// File: rtl/ckdiv_regs.sv
module ckdiv_regs
  import ckdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output cfg_t        cfg
);
  cfg_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q.mux <= wdata[MUX_LSB +: SEL_W];
      q.sh  <= wdata[SH_LSB  +: SH_W];
      q.dv  <= wdata[DV_LSB  +: DV_W];
    end
  end

  // Bits outside the three fields are dropped on purpose.
  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:MUX_LSB+SEL_W], wdata[MUX_LSB-1:DV_LSB+DV_W],
                          wdata[DV_LSB-1:SH_LSB+SH_W], wdata[SH_LSB-1:0]};

  assign rdata = cfg_to_word(q);
  assign cfg   = q;

  // R3: without a strobe the stored word must not move
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/ckdiv_edges.sv
module ckdiv_edges #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= src[i];
        s2 <= s1;
      end
    end
    assign lvl[i]  = s1;
    assign rise[i] = s1 & ~s2;
  end
endmodule

// File: rtl/ckdiv_pre.sv
module ckdiv_pre
  import ckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [SH_W-1:0]  sh,
  output logic             wrap,
  output logic [PRE_W-1:0] cnt_nx
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  assign last   = PRE_W'((32'd1 << sh) - 32'd1);
  assign wrap   = step && (cnt_q == last);
  assign cnt_nx = !step ? cnt_q : (wrap ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

  // R4: prescale count stays inside 0 .. 2^S-1
  a_r4_pre_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);
endmodule

// File: rtl/ckdiv_int.sv
module ckdiv_int
  import ckdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic [DV_W-1:0] dv,
  output logic            wrap,
  output logic [DV_W-1:0] cnt_nx
);
  logic [DV_W-1:0] cnt_q;

  assign wrap   = step && (cnt_q == dv);
  assign cnt_nx = !step ? cnt_q : (wrap ? '0 : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

  // R4: second-stage count never passes N
  a_r4_div_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= dv);
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
  import ckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [NSRC-1:0]  src_clk,
  output logic             out_clk,
  output logic             out_tick,
  output logic [SEL_W-1:0] act_src
);
  cfg_t pend, act_q, act_n;
  logic park_q, park_n, out_q, out_n, tick_q, tick_n;
  logic [NSRC-1:0] lvl, rise;
  logic rise_act, step, pre_wrap, bnd, mux_chg, unit_n;
  logic [PRE_W-1:0] pre_nx;
  logic [DV_W-1:0]  div_nx;
  logic [POS_W-1:0] pos_n;
  logic [RAT_W-1:0] rat_n, half_n;

  ckdiv_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(pend)
  );

  ckdiv_edges #(.N(NSRC)) u_edges (
    .clk(clk), .rst(rst), .src(src_clk), .lvl(lvl), .rise(rise)
  );

  assign rise_act = rise[act_q.mux];
  assign step     = rise_act & ~park_q;

  ckdiv_pre u_pre (
    .clk(clk), .rst(rst), .step(step), .sh(act_q.sh),
    .wrap(pre_wrap), .cnt_nx(pre_nx)
  );

  ckdiv_int u_int (
    .clk(clk), .rst(rst), .step(pre_wrap), .dv(act_q.dv),
    .wrap(bnd), .cnt_nx(div_nx)
  );

  // Period boundary: apply pending word; a new source parks the output.
  always_comb begin
    mux_chg = (pend.mux != act_q.mux);
    act_n   = bnd ? pend : act_q;
    park_n  = bnd ? mux_chg : (park_q & ~rise_act);
    tick_n  = (bnd & ~mux_chg) | (park_q & rise_act);
    pos_n   = (POS_W'(div_nx) << act_n.sh) | POS_W'(pre_nx);
    rat_n   = (RAT_W'(act_n.dv) + RAT_W'(1)) << act_n.sh;
    half_n  = rat_n >> 1;
    unit_n  = (act_n.sh == '0) && (act_n.dv == '0);
    if (park_n)      out_n = 1'b0;
    else if (unit_n) out_n = lvl[act_n.mux];
    else             out_n = ({1'b0, pos_n} < half_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      park_q <= 1'b0;
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      park_q <= park_n;
      out_q  <= out_n;
      tick_q <= tick_n;
    end
  end

  assign out_clk  = out_q;
  assign out_tick = tick_q;
  assign act_src  = act_q.mux;

  // R8: parked output is low
  a_r8_park_low: assert property (@(posedge clk) disable iff (rst)
    park_q |-> !out_clk);
  // R7: active configuration moves only at a period start or park entry
  a_r7_cfg_boundary: assert property (@(posedge clk) disable iff (rst)
    (!tick_q && !$rose(park_q)) |-> $stable(act_q));
  // R9: without an edge of the active source nothing advances
  a_r9_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
    !rise_act |=> ($stable(act_q) && $stable(park_q) && !out_tick));
  // R4: the period tick is a single-cycle pulse
  a_r4_tick_pulse: assert property (@(posedge clk) disable iff (rst)
    out_tick |=> !out_tick);
endmodule

// File: tb/ckdiv_top_bench.sv
module ckdiv_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  src = '0;
  logic        out_clk, out_tick;
  logic [1:0]  act_src;

  ckdiv_top u_ckdiv_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .src_clk(src), .out_clk(out_clk),
    .out_tick(out_tick), .act_src(act_src)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, seen_ticks = 0;
  int m_mux = 0, m_sh = 0, m_dv = 0, p_mux = 0, p_sh = 0, p_dv = 0;
  int m_pos = 0, m_park = 0, m_ticks = 0;
  string cur_tag = "";

  always @(negedge clk) if (!rst && out_tick) seen_ticks++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int ratio();
    return (m_dv + 1) << m_sh;
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 32'hDEAD_BEEF;
    p_mux = int'(d[17:16]); p_sh = int'(d[5:4]); p_dv = int'(d[12:8]);
    @(negedge clk);
  endtask

  task automatic model_rise(input int i);
    if (m_park != 0) begin
      if (i == m_mux) begin m_park = 0; m_pos = 0; m_ticks++; end
    end else if (i == m_mux) begin
      if (m_pos == ratio() - 1) begin
        if (p_mux != m_mux) m_park = 1; else m_ticks++;
        m_mux = p_mux; m_sh = p_sh; m_dv = p_dv; m_pos = 0;
      end else m_pos++;
    end
  endtask

  task automatic flip(input int i);
    int exp_o;
    string t;
    @(negedge clk);
    src[i] = ~src[i];
    if (src[i]) model_rise(i);
    repeat (3) @(negedge clk);
    if (m_park != 0)       begin exp_o = 0; t = "R8"; end
    else if (ratio() == 1) begin exp_o = int'(src[m_mux]); t = "R6"; end
    else                   begin exp_o = (m_pos < ratio() / 2) ? 1 : 0; t = "R5"; end
    if (cur_tag != "") t = cur_tag;
    chk(out_clk == exp_o[0], t, int'(out_clk), exp_o);
    chk(int'(act_src) == m_mux, "R8 act_src", int'(act_src), m_mux);
  endtask

  task automatic settle();
    for (int k = 0; k < 800; k++) begin
      if (m_park == 0 && m_mux == p_mux && m_sh == p_sh && m_dv == p_dv) break;
      flip(m_mux);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
  end

  int dv_list[9] = '{0, 1, 2, 3, 4, 6, 15, 30, 31};

  initial begin
    logic [31:0] rb;
    int cfgn;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 32'h0, "R1 rdata", int'(cfg_rdata), 0);
    chk(out_clk == 1'b0, "R1 out_clk", int'(out_clk), 0);
    chk(out_tick == 1'b0, "R1 out_tick", int'(out_tick), 0);
    chk(act_src == 2'd0, "R1 act_src", int'(act_src), 0);

    // R2 field layout and unused bits
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h0003_1F30, "R2 all-ones", int'(cfg_rdata), 32'h0003_1F30);
    wr(32'hFFFC_E0CF | (32'd2 << 16) | (32'd7 << 8) | (32'd1 << 4));
    chk(cfg_rdata == 32'h0002_0710, "R2 fields", int'(cfg_rdata), 32'h0002_0710);
    // R3 no strobe, junk data
    @(negedge clk); cfg_wdata = 32'h1234_5678;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 32'h0002_0710, "R3 hold", int'(cfg_rdata), 32'h0002_0710);
    // R3 read-modify-write of the source field only
    rb = cfg_rdata;
    rb[17:16] = 2'd1;
    wr(rb);
    chk(cfg_rdata == 32'h0001_0710, "R3 rmw mux", int'(cfg_rdata), 32'h0001_0710);
    rb = cfg_rdata;
    rb[12:8] = 5'd3;
    wr(rb);
    chk(cfg_rdata == 32'h0001_0310, "R3 rmw div", int'(cfg_rdata), 32'h0001_0310);
    // R7: ratio-1 active; odd ratio pending is applied at the next source-0 edge
    wr(32'h0000_0000);
    cur_tag = "R6";
    for (int k = 0; k < 4; k++) flip(0);
    wr(32'h0000_0200);           // N=2, ratio 3
    cur_tag = "R7";
    for (int k = 0; k < 12; k++) flip(0);
    // write ratio 4 mid-period: old ratio-3 pattern must go on until the boundary
    flip(0);
    wr(32'h0000_0110);
    for (int k = 0; k < 16; k++) flip(0);
    cur_tag = "";

    // sweep: every shift, a spread of N, rotating sources
    cfgn = 0;
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 9; j++) begin
        int mx;
        int base;
        mx = cfgn % 4;
        cfgn++;
        wr((32'(mx) << 16) | (32'(dv_list[j]) << 8) | (32'(s) << 4));
        settle();
        chk(m_park == 0 && m_mux == mx, "R8 switched", m_mux, mx);
        base = seen_ticks - m_ticks;
        for (int e = 0; e < 2 * ratio(); e++) begin
          flip(m_mux);
          flip(m_mux);
          if (e % 5 == 2) begin
            cur_tag = "R9";
            flip((m_mux + 1) % 4);
            flip((m_mux + 1) % 4);
            cur_tag = "";
          end
        end
        chk(seen_ticks - base == m_ticks, "R4 tick count",
            seen_ticks - base, m_ticks);
      end
    end
    summary();
  end
endmodule